// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between one processor port and a cache controller and keeps account of every memory request still in flight. Requests are classed as read-class or write-class from a 4-bit kind code. Each class has its own small fully associative table whose key is the cache-line address, which is the request address with the offset bits inside the line cleared. A new request is issued only when three conditions hold: the combined count of outstanding entries is below a limit, no request to the same line is pending in the other class's table, and no request to the same line is pending in its own class's table. Otherwise the request is refused with a full status or an alias status, and the table is left as it was.

Four event counters record each kind of alias refusal. A completion strobe carries a line address and a table selector, and it frees the matching entry. A completion in the same cycle as a request is applied first, so the freed slot and the freed line are already visible to that request. An age watchdog runs while anything is outstanding. Once per threshold period it scans both tables, and it raises a sticky hang flag with the line address of an entry that has been outstanding for the threshold or longer.

Top module: `line_req_tracker`

## Requirements
- R1: After synchronous reset the outstanding count, all four alias counters, `rsp_valid`, `cmp_err` and `hang_err` are zero.
- R2: Matching uses only the line address, which is the address with its low log2(LINE_BYTES) bits cleared (64-byte lines by default). Two addresses in the same line alias, and addresses in different lines do not.
- R3: Kind codes 0 (load) and 1 (instruction fetch) are read-class. Codes 2 to 9 are write-class: store, read-for-modify, write-for-modify, load-linked, store-conditional, locked read, locked write and flush. Every request gets `rsp_valid` one cycle later. An accepted request reports status 0 (issued), its entry goes into its class's table, and the count rises by one.
- R4: If the count, after any same-cycle completion, is at or above MAX_OUT, the request reports status 1 (full). No table, count or alias counter changes.
- R5: A write-class request whose line is pending in the read table reports status 2 (alias) and increments `st_behind_ld`. If the line is instead pending in the write table, it reports status 2 and increments `st_behind_st`.
- R6: A read-class request whose line is pending in the write table reports status 2 and increments `ld_behind_st`. If the line is instead pending in the read table, it reports status 2 and increments `ld_behind_ld`.
- R7: A completion with `cmp_write` selecting the table removes the matching line's entry, the count falls by one on the next cycle, and that line may then be requested again.
- R8: A completion that matches no valid entry in the selected table sets the sticky `cmp_err` and leaves the count unchanged.
- R9: A completion and a request in the same cycle are resolved with the removal first, for both the full check and the alias check.
- R10: The outstanding count always equals the sum of the two tables' occupancies and never exceeds MAX_OUT.
- R11: While any entry is outstanding, a check runs every THRESH cycles. `hang_err` is never set for an entry younger than THRESH cycles. It is set within 2*THRESH cycles of acceptance for an entry that stays outstanding. It is sticky, and `hang_addr` holds the line address of the first aged entry found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request strobe |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 4 | Request kind code |
| rsp_valid | output | 1 | Status valid, one cycle after req_valid |
| rsp_status | output | 2 | 0 issued, 1 full, 2 alias |
| cmp_valid | input | 1 | Completion strobe |
| cmp_write | input | 1 | Completion selects the write table when 1, the read table when 0 |
| cmp_addr | input | ADDR_W | Completion address |
| outstanding | output | CNT_W | Outstanding entry count |
| st_behind_ld | output | EVT_W | Write-class refused by a pending read |
| st_behind_st | output | EVT_W | Write-class refused by a pending write |
| ld_behind_ld | output | EVT_W | Read-class refused by a pending read |
| ld_behind_st | output | EVT_W | Read-class refused by a pending write |
| cmp_err | output | 1 | Sticky unmatched-completion flag |
| hang_err | output | 1 | Sticky age watchdog flag |
| hang_addr | output | ADDR_W | Line address of the first aged entry |

## Verification
Completion and admission can fall in the same cycle, and that case is the one that exposes ordering mistakes. The bench fills the tracker to its limit, then in a single cycle completes a pending load and presents a new request that would otherwise be refused as full. An issued status and an unchanged count of MAX_OUT show that the removal was applied before the admission check. A completion that frees a line, followed later by a new write-class request to the same line, shows that freed entries no longer alias.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    typedef enum logic [3:0] {
        K_LOAD      = 4'd0,
        K_IFETCH    = 4'd1,
        K_STORE     = 4'd2,
        K_MOD_RD    = 4'd3,
        K_MOD_WR    = 4'd4,
        K_LINK_LD   = 4'd5,
        K_COND_ST   = 4'd6,
        K_LOCK_RD   = 4'd7,
        K_LOCK_WR   = 4'd8,
        K_FLUSH     = 4'd9
    } kind_e;

    typedef enum logic [1:0] {
        ST_ISSUED = 2'd0,
        ST_FULL   = 2'd1,
        ST_ALIAS  = 2'd2
    } status_e;

    // alias event slots
    localparam int EV_ST_LD = 0;
    localparam int EV_ST_ST = 1;
    localparam int EV_LD_LD = 2;
    localparam int EV_LD_ST = 3;

    function automatic logic is_write_class(input logic [3:0] kind);
        return kind >= 4'd2;
    endfunction

endpackage

// File: rtl/lrt_ager.sv
module lrt_ager #(
    parameter int THRESH = 64,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    output logic [TIME_W-1:0] now,
    output logic              tick
);
    localparam int PER_W = (THRESH > 2) ? $clog2(THRESH) : 1;

    logic [PER_W-1:0] phase;

    assign tick = busy && (phase == PER_W'(THRESH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            now   <= '0;
            phase <= '0;
        end else begin
            now <= now + 1'b1;
            if (!busy || tick) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/lrt_table.sv
module lrt_table #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 32,
    parameter int TIME_W = 8,
    parameter int THRESH = 64,
    parameter int OCC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    input  logic              rm_en,
    input  logic [TAG_W-1:0]  rm_tag,
    output logic              rm_hit,
    input  logic              ins_en,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [TIME_W-1:0] now,
    output logic [OCC_W-1:0]  occ,
    output logic              aged,
    output logic [TAG_W-1:0]  aged_tag
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [TIME_W-1:0] born;
    } entry_t;

    entry_t           slot [DEPTH];
    logic [DEPTH-1:0] hit_lk, hit_rm, gone, free_v, old_v;
    logic [IDX_W-1:0] ins_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign hit_lk[i] = slot[i].valid && (slot[i].tag == lk_tag);
        assign hit_rm[i] = slot[i].valid && (slot[i].tag == rm_tag);
        assign gone[i]   = rm_en && hit_rm[i];
        assign free_v[i] = !slot[i].valid || gone[i];
        assign old_v[i]  = slot[i].valid &&
                           ((now - slot[i].born) >= TIME_W'(THRESH));
    end

    // removal takes effect before the lookup of a same-cycle request
    assign lk_hit = |(hit_lk & ~gone);
    assign rm_hit = |gone;
    assign aged   = |old_v;

    always_comb begin
        ins_idx  = '0;
        aged_tag = '0;
        occ      = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_v[i]) ins_idx  = IDX_W'(i);
            if (old_v[i])  aged_tag = slot[i].tag;
        end
        for (int i = 0; i < DEPTH; i++)
            occ = occ + OCC_W'(slot[i].valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (gone[i]) slot[i].valid <= 1'b0;
                if (ins_en && (ins_idx == IDX_W'(i)))
                    slot[i] <= '{valid: 1'b1, tag: ins_tag, born: now};
            end
        end
    end
endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
    import lrt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 4,
    parameter int THRESH     = 64,
    parameter int EVT_W      = 8,
    localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_kind,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    input  logic              cmp_valid,
    input  logic              cmp_write,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic [CNT_W-1:0]  outstanding,
    output logic [EVT_W-1:0]  st_behind_ld,
    output logic [EVT_W-1:0]  st_behind_st,
    output logic [EVT_W-1:0]  ld_behind_ld,
    output logic [EVT_W-1:0]  ld_behind_st,
    output logic              cmp_err,
    output logic              hang_err,
    output logic [ADDR_W-1:0] hang_addr
);
    localparam int TIME_W = $clog2(THRESH) + 2;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

    logic [ADDR_W-1:0] req_line, cmp_line, rd_old_tag, wr_old_tag;
    logic              rd_hit, wr_hit, rd_rm_hit, wr_rm_hit;
    logic              rd_old, wr_old, removed, wcls, accept, tick;
    logic [CNT_W-1:0]  rd_occ, wr_occ, cnt_after;
    logic [TIME_W-1:0] now;
    logic [3:0]        evt;
    status_e           stat;

    assign req_line = req_addr & LINE_MASK;
    assign cmp_line = cmp_addr & LINE_MASK;
    assign wcls     = is_write_class(req_kind);

    lrt_table #(.DEPTH(MAX_OUT), .TAG_W(ADDR_W), .TIME_W(TIME_W),
                .THRESH(THRESH), .OCC_W(CNT_W)) rd_tbl (
        .clk(clk), .rst(rst), .lk_tag(req_line), .lk_hit(rd_hit),
        .rm_en(cmp_valid && !cmp_write), .rm_tag(cmp_line), .rm_hit(rd_rm_hit),
        .ins_en(accept && !wcls), .ins_tag(req_line), .now(now),
        .occ(rd_occ), .aged(rd_old), .aged_tag(rd_old_tag));

    lrt_table #(.DEPTH(MAX_OUT), .TAG_W(ADDR_W), .TIME_W(TIME_W),
                .THRESH(THRESH), .OCC_W(CNT_W)) wr_tbl (
        .clk(clk), .rst(rst), .lk_tag(req_line), .lk_hit(wr_hit),
        .rm_en(cmp_valid && cmp_write), .rm_tag(cmp_line), .rm_hit(wr_rm_hit),
        .ins_en(accept && wcls), .ins_tag(req_line), .now(now),
        .occ(wr_occ), .aged(wr_old), .aged_tag(wr_old_tag));

    lrt_ager #(.THRESH(THRESH), .TIME_W(TIME_W)) ager (
        .clk(clk), .rst(rst), .busy(outstanding != '0), .now(now), .tick(tick));

    assign removed   = rd_rm_hit || wr_rm_hit;
    assign cnt_after = outstanding - CNT_W'(removed);

    always_comb begin
        accept = 1'b0;
        stat   = ST_ISSUED;
        evt    = '0;
        if (req_valid) begin
            if (cnt_after >= CNT_W'(MAX_OUT)) begin
                stat = ST_FULL;
            end else if (wcls) begin
                if (rd_hit)      begin stat = ST_ALIAS; evt[EV_ST_LD] = 1'b1; end
                else if (wr_hit) begin stat = ST_ALIAS; evt[EV_ST_ST] = 1'b1; end
                else             accept = 1'b1;
            end else begin
                if (wr_hit)      begin stat = ST_ALIAS; evt[EV_LD_ST] = 1'b1; end
                else if (rd_hit) begin stat = ST_ALIAS; evt[EV_LD_LD] = 1'b1; end
                else             accept = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding  <= '0;
            rsp_valid    <= 1'b0;
            rsp_status   <= ST_ISSUED;
            st_behind_ld <= '0;
            st_behind_st <= '0;
            ld_behind_ld <= '0;
            ld_behind_st <= '0;
            cmp_err      <= 1'b0;
            hang_err     <= 1'b0;
            hang_addr    <= '0;
        end else begin
            outstanding <= cnt_after + CNT_W'(accept);
            rsp_valid   <= req_valid;
            rsp_status  <= stat;
            if (evt[EV_ST_LD]) st_behind_ld <= st_behind_ld + 1'b1;
            if (evt[EV_ST_ST]) st_behind_st <= st_behind_st + 1'b1;
            if (evt[EV_LD_LD]) ld_behind_ld <= ld_behind_ld + 1'b1;
            if (evt[EV_LD_ST]) ld_behind_st <= ld_behind_st + 1'b1;
            if (cmp_valid && !removed) cmp_err <= 1'b1;
            if (!hang_err && tick && (rd_old || wr_old)) begin
                hang_err  <= 1'b1;
                hang_addr <= rd_old ? rd_old_tag : wr_old_tag;
            end
        end
    end
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker #(
    parameter int MAX_OUT = 4,
    parameter int CNT_W   = 3,
    parameter int ADDR_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [CNT_W-1:0]  outstanding,
    input logic [CNT_W-1:0]  rd_occ,
    input logic [CNT_W-1:0]  wr_occ,
    input logic              cmp_err,
    input logic              hang_err,
    input logic [ADDR_W-1:0] hang_addr
);
    // R10
    count_sum_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, outstanding} == ({1'b0, rd_occ} + {1'b0, wr_occ})));

    // R10
    count_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (outstanding <= CNT_W'(MAX_OUT)));

    // R4
    refused_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> (outstanding <= $past(outstanding)));

    // R3
    issued_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |-> (outstanding != '0));

    // R8
    cmp_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_err |=> cmp_err);

    // R11
    hang_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        hang_err |=> (hang_err && $stable(hang_addr)));
endmodule

bind line_req_tracker lrt_checker #(
    .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .outstanding(outstanding), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .cmp_err(cmp_err), .hang_err(hang_err), .hang_addr(hang_addr)
);

// File: tb/line_req_tracker_test.sv
`timescale 1ns/1ps
module line_req_tracker_test;
    localparam int MAXO = 4;
    localparam int TH   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_kind = '0;
    logic        cmp_valid = 1'b0;
    logic        cmp_write = 1'b0;
    logic [31:0] cmp_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [2:0]  outstanding;
    logic [7:0]  st_behind_ld, st_behind_st, ld_behind_ld, ld_behind_st;
    logic        cmp_err, hang_err;
    logic [31:0] hang_addr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    line_req_tracker #(.ADDR_W(32), .LINE_BYTES(64), .MAX_OUT(MAXO),
                       .THRESH(TH), .EVT_W(8)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .cmp_valid(cmp_valid), .cmp_write(cmp_write), .cmp_addr(cmp_addr),
        .outstanding(outstanding), .st_behind_ld(st_behind_ld),
        .st_behind_st(st_behind_st), .ld_behind_ld(ld_behind_ld),
        .ld_behind_st(ld_behind_st), .cmp_err(cmp_err), .hang_err(hang_err),
        .hang_addr(hang_addr));

    task automatic check(input string tg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
        end
    endtask

    // monitor: pops expected statuses as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(rsp_status), 32'(e));
            end
        end
    end

    task automatic step(input logic rv, input logic [31:0] ra, input logic [3:0] rk,
                        input logic [1:0] ex, input logic cv, input logic cw,
                        input logic [31:0] ca, input string tg);
        @(negedge clk);
        req_valid = rv; req_addr = ra; req_kind = rk;
        cmp_valid = cv; cmp_write = cw; cmp_addr = ca;
        if (rv) begin exp_q.push_back(ex); tag_q.push_back(tg); end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        cmp_valid = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input logic [3:0] k,
                         input logic [1:0] ex, input string tg);
        step(1'b1, a, k, ex, 1'b0, 1'b0, 32'd0, tg);
    endtask

    task automatic complete(input logic wr, input logic [31:0] a, input string tg);
        step(1'b0, 32'd0, 4'd0, 2'd0, 1'b1, wr, a, tg);
    endtask

    task automatic look;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        look();
        check("R1 count", 32'(outstanding), 0);
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 flags", {30'd0, cmp_err, hang_err}, 0);
        check("R1 counters", {st_behind_ld, st_behind_st, ld_behind_ld, ld_behind_st}, 0);

        issue(32'h1004, 4'd0, 2'd0, "R3 load A issued");
        look(); check("R3 count 1", 32'(outstanding), 1);
        issue(32'h1030, 4'd0, 2'd2, "R2 same line load alias");
        look(); check("R6 ld_behind_ld", 32'(ld_behind_ld), 1);
        issue(32'h1008, 4'd2, 2'd2, "R5 store on pending load");
        look(); check("R5 st_behind_ld", 32'(st_behind_ld), 1);
        issue(32'h2040, 4'd2, 2'd0, "R3 store B issued");
        issue(32'h2044, 4'd0, 2'd2, "R6 load on pending store");
        look(); check("R6 ld_behind_st", 32'(ld_behind_st), 1);
        issue(32'h2050, 4'd5, 2'd2, "R5 linked load on pending store");
        look(); check("R5 st_behind_st", 32'(st_behind_st), 1);
        issue(32'h3080, 4'd1, 2'd0, "R3 ifetch C issued");
        issue(32'h40C0, 4'd9, 2'd0, "R3 flush D issued");
        look(); check("R3 count 4", 32'(outstanding), 4);

        issue(32'h5000, 4'd0, 2'd1, "R4 load when full");
        issue(32'h5000, 4'd2, 2'd1, "R4 store when full");
        look(); check("R4 count held", 32'(outstanding), 4);
        check("R4 counters held", {st_behind_ld, st_behind_st, ld_behind_ld, ld_behind_st},
              32'h01010101);

        // same cycle: completion of A frees space for load E
        step(1'b1, 32'h5000, 4'd0, 2'd0, 1'b1, 1'b0, 32'h1000, "R9 admit with same-cycle completion");
        look(); check("R9 count stays 4", 32'(outstanding), 4);

        complete(1'b1, 32'h1000, "R8 unmatched");
        look(); check("R8 cmp_err", 32'(cmp_err), 1);
        check("R8 count unchanged", 32'(outstanding), 4);

        complete(1'b0, 32'h5010, "R7 done E");
        complete(1'b0, 32'h3080, "R7 done C");
        complete(1'b1, 32'h2040, "R7 done B");
        complete(1'b1, 32'h40C0, "R7 done D");
        look(); check("R7 count 0", 32'(outstanding), 0);
        issue(32'h2048, 4'd6, 2'd0, "R7 freed line reused");
        complete(1'b1, 32'h2040, "R7 done reuse");
        look(); check("R7 count back 0", 32'(outstanding), 0);
        check("R11 no hang yet", 32'(hang_err), 0);

        issue(32'h6003, 4'd7, 2'd0, "R11 locked read F issued");
        repeat (TH - 3) look();
        check("R11 not before threshold", 32'(hang_err), 0);
        repeat (TH + 5) look();
        check("R11 hang raised", 32'(hang_err), 1);
        check("R11 hang line", hang_addr, 32'h6000);

        repeat (3) look();
        check("R3 all responses seen", 32'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule